// File: doc/BRIEF.md
# Thread Serial Number Allocator

This block manages a fixed pool of 28 thread serial numbers, each an 8-bit value that is not contiguous with its neighbours. A client pulses an allocate request. In the next cycle the block returns the value of the free pool slot with the lowest index and marks that slot used. If no slot is free, it raises a busy flag instead.

A release request carries a number value, not a slot index. The block searches the pool for the first slot holding that value and marks it free. When an allocate and a release arrive in the same cycle, the release is applied first, so the number just freed can be granted at once. A free-count output always shows how many slots are available.

Pool contents follow a fixed rule. Slots 0 to 13 hold 0x04 + 8·(i/2) + (i mod 2). Slots 14 to 27 hold 0x88 + 16·((i−14)/2) + ((i−14) mod 2). This gives 0x04, 0x05, 0x0C, …, 0x35, then 0x88, 0x89, 0x98, …, 0xE9.

Top module: `tsn_pool_alloc`

## Requirements
- R1: While `rst` is sampled high, the block marks every slot free. From the edge that samples it, `free_cnt` reads 28, and `grant_vld` and `busy` read 0.
- R2: An allocate request grants the free slot with the lowest index. One edge later, `grant_vld` is 1 and `grant_num` holds that slot's value, given by the pool rule above. The slot becomes used.
- R3: An allocate request made when no slot is free (after any release in that cycle) gives `busy`=1 and `grant_vld`=0 one edge later. The pool is not changed.
- R4: A release whose `rel_num` equals a pool value marks the lowest-index slot holding that value free.
- R5: A release whose `rel_num` is not a pool value (for example 0x07 or 0x00) changes no slot and leaves `free_cnt` unchanged.
- R6: Releasing a value whose slot is already free leaves the pool and `free_cnt` unchanged.
- R7: With allocate and release in the same cycle, the release is applied first. When the pool is otherwise full, the released value is granted in that same transaction.
- R8: After each edge, `free_cnt` equals the number of free slots, in the range 0 to 28.
- R9: All outputs are registered with a latency of one edge. In a cycle with no allocate request, `grant_vld` and `busy` are both 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request one serial number |
| rel_req | input | 1 | Return the number on `rel_num` |
| rel_num | input | 8 | Value being returned |
| grant_vld | output | 1 | A number was granted |
| grant_num | output | 8 | Granted value, meaningful when `grant_vld` is 1 |
| busy | output | 1 | The allocate request found no free slot |
| free_cnt | output | 5 | Number of free slots |

## Verification
The hardest state to reach is a completely full pool that receives a release and an allocate in the same cycle, since only that shows the ordering of the two operations. The stimulus allocates all 28 slots and confirms `busy` on a further request. It then issues combined release-and-allocate transactions for values at both ends of the table and checks that each freed value is granted back at once. Long stretches of mixed random traffic then revisit the full and empty boundaries, including releases of values outside the table and of slots that are already free.

// File: rtl/tsn_pkg.sv
package tsn_pkg;

  // Value held by pool slot idx; half is the slot count of the first group.
  function automatic int tsn_slot_value(int idx, int half);
    int j;
    if (idx < half) begin
      return 32'h04 + 8 * (idx / 2) + (idx % 2);
    end
    j = idx - half;
    return 32'h88 + 16 * (j / 2) + (j % 2);
  endfunction

endpackage

// File: rtl/tsn_first_one.sv
module tsn_first_one #(
  parameter int N  = 28,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  oh,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    oh    = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        oh    = '0;
        oh[i] = 1'b1;
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsn_value_match.sv
module tsn_value_match #(
  parameter int N = 28,
  parameter int W = 8
) (
  input  logic [N-1:0][W-1:0] pool,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        hit_oh,
  output logic                any_hit
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  eq;
  logic [IW-1:0] unused_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (pool[g] == key);
  end

  tsn_first_one #(.N(N), .IW(IW)) u_first (
    .req   (eq),
    .oh    (hit_oh),
    .idx   (unused_idx),
    .found (any_hit)
  );
endmodule

// File: rtl/tsn_popcount.sv
module tsn_popcount #(
  parameter int N  = 28,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/tsn_pool_alloc.sv
module tsn_pool_alloc #(
  parameter int N_ENTRIES = 28,
  parameter int NUM_W     = 8,
  parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             rel_req,
  input  logic [NUM_W-1:0] rel_num,
  output logic             grant_vld,
  output logic [NUM_W-1:0] grant_num,
  output logic             busy,
  output logic [CNT_W-1:0] free_cnt
);
  localparam int IW   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int HALF = N_ENTRIES / 2;

  // Constant pool contents
  logic [N_ENTRIES-1:0][NUM_W-1:0] pool_val;
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_pool
    assign pool_val[g] = NUM_W'(tsn_pkg::tsn_slot_value(g, HALF));
  end

  logic [N_ENTRIES-1:0] free_q, free_mid, free_d;
  logic [N_ENTRIES-1:0] hit_oh, pick_oh;
  logic                 any_hit, pick_found, take;
  logic [IW-1:0]        pick_idx;
  logic [CNT_W-1:0]     cnt_d;

  // Release lookup by value
  tsn_value_match #(.N(N_ENTRIES), .W(NUM_W)) u_match (
    .pool    (pool_val),
    .key     (rel_num),
    .hit_oh  (hit_oh),
    .any_hit (any_hit)
  );

  // Release applies before allocation in the same cycle
  always_comb begin
    free_mid = free_q;
    if (rel_req && any_hit) begin
      free_mid = free_q | hit_oh;
    end
  end

  tsn_first_one #(.N(N_ENTRIES), .IW(IW)) u_pick (
    .req   (free_mid),
    .oh    (pick_oh),
    .idx   (pick_idx),
    .found (pick_found)
  );

  assign take = alloc_req && pick_found;

  always_comb begin
    free_d = free_mid;
    if (take) begin
      free_d = free_mid & ~pick_oh;
    end
  end

  tsn_popcount #(.N(N_ENTRIES), .CW(CNT_W)) u_count (
    .bits  (free_d),
    .count (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q    <= '1;
      grant_vld <= 1'b0;
      grant_num <= '0;
      busy      <= 1'b0;
      free_cnt  <= CNT_W'(N_ENTRIES);
    end else begin
      free_q    <= free_d;
      grant_vld <= take;
      busy      <= alloc_req && !pick_found;
      free_cnt  <= cnt_d;
      if (take) begin
        grant_num <= pool_val[pick_idx];
      end
    end
  end
endmodule

// File: rtl/tsn_pool_chk.sv
module tsn_pool_chk #(
  parameter int N_ENTRIES = 28,
  parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_req,
  input logic             rel_req,
  input logic             grant_vld,
  input logic             busy,
  input logic [CNT_W-1:0] free_cnt
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (free_cnt == CNT_W'(N_ENTRIES)) && !grant_vld && !busy);

  assert_busy_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(grant_vld && busy));

  assert_busy_only_empty_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (free_cnt == '0));

  assert_grant_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !rel_req && $past(!rst) && free_cnt != '0) |=>
      grant_vld && (free_cnt == $past(free_cnt) - 1'b1));

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(N_ENTRIES));

  assert_idle_out_R9: assert property (@(posedge clk) disable iff (rst)
    !alloc_req |=> !grant_vld && !busy);

  assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (rst)
    (!alloc_req && !rel_req && $past(!rst)) |=> $stable(free_cnt));
endmodule

bind tsn_pool_alloc tsn_pool_chk #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .alloc_req (alloc_req),
  .rel_req   (rel_req),
  .grant_vld (grant_vld),
  .busy      (busy),
  .free_cnt  (free_cnt)
);

// File: tb/tb_tsn_pool_alloc.sv
`timescale 1ns/1ps
module tb_tsn_pool_alloc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_req = 1'b0;
  logic       rel_req = 1'b0;
  logic [7:0] rel_num = 8'h00;
  logic       grant_vld;
  logic [7:0] grant_num;
  logic       busy;
  logic [4:0] free_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tsn_pool_alloc dut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .rel_req(rel_req),
    .rel_num(rel_num), .grant_vld(grant_vld), .grant_num(grant_num),
    .busy(busy), .free_cnt(free_cnt)
  );

  // Reference model
  int tbl [28] = '{8'h04, 8'h05, 8'h0C, 8'h0D, 8'h14, 8'h15, 8'h1C, 8'h1D,
                   8'h24, 8'h25, 8'h2C, 8'h2D, 8'h34, 8'h35, 8'h88, 8'h89,
                   8'h98, 8'h99, 8'hA8, 8'hA9, 8'hB8, 8'hB9, 8'hC8, 8'hC9,
                   8'hD8, 8'hD9, 8'hE8, 8'hE9};
  bit m_free [28];
  bit e_vld, e_busy;
  int e_num, e_cnt;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "grant_vld", int'(grant_vld), int'(e_vld));
    chk(tag, "busy", int'(busy), int'(e_busy));
    chk(tag, "free_cnt", int'(free_cnt), e_cnt);
    if (e_vld) chk(tag, "grant_num", int'(grant_num), e_num);
  endtask

  task automatic step(bit a, bit r, logic [7:0] n, string tag);
    alloc_req = a; rel_req = r; rel_num = n;
    if (r) begin
      for (int i = 0; i < 28; i++) begin
        if (tbl[i] == int'(n)) begin m_free[i] = 1'b1; break; end
      end
    end
    e_vld = 1'b0; e_busy = 1'b0;
    if (a) begin
      e_busy = 1'b1;
      for (int i = 0; i < 28; i++) begin
        if (m_free[i]) begin
          m_free[i] = 1'b0; e_vld = 1'b1; e_busy = 1'b0; e_num = tbl[i];
          break;
        end
      end
    end
    e_cnt = 0;
    for (int i = 0; i < 28; i++) e_cnt += int'(m_free[i]);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 28; i++) m_free[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_vld = 0; e_busy = 0; e_cnt = 28;
    compare("R1");

    // R2: lowest-index grants
    for (int k = 0; k < 5; k++) step(1, 0, 8'h00, "R2");
    // R4: release by value, then re-grant of that slot
    step(0, 1, 8'h0C, "R4");
    step(1, 0, 8'h00, "R2");
    // R5: values outside the table
    step(0, 1, 8'h07, "R5");
    step(0, 1, 8'h00, "R5");
    step(0, 0, 8'h00, "R9");
    // R6: release of an already-free slot
    step(0, 1, 8'h88, "R6");
    step(0, 1, 8'hE9, "R6");
    // Fill the pool
    for (int k = 0; k < 23; k++) step(1, 0, 8'h00, "R8");
    // R3: empty pool
    step(1, 0, 8'h00, "R3");
    step(1, 1, 8'h07, "R3");
    // R7: combined release and allocate on full pool
    step(1, 1, 8'h35, "R7");
    step(1, 1, 8'hE9, "R7");
    step(1, 1, 8'h04, "R7");
    step(0, 0, 8'h00, "R9");
    // Mixed traffic
    for (int k = 0; k < 600; k++) begin
      bit a, r;
      logic [7:0] n;
      a = ($urandom % 2) == 0;
      r = ($urandom % 3) != 0;
      n = (($urandom % 5) == 0) ? 8'($urandom) : 8'(tbl[$urandom % 28]);
      step(a, r, n, "R8");
    end
    // Drain and idle
    for (int i = 0; i < 28; i++) step(0, 1, 8'(tbl[i]), "R4");
    step(0, 0, 8'h00, "R9");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule